// File: doc/BRIEF.md
# Lane-Banked SIMD Multiply-Add Pipeline

This block is a 16-lane vector execution slice that runs 64-element wavefront instructions. Every instruction is a three-operand integer multiply-add, `dst = src0 * src1 + src2`. It is carried out as four quarter-wave passes, one for each group of 16 lanes. The vector register file is split into four banks. Bank k holds lanes 16k..16k+15 of every register and has a single port. Each cycle that port serves either one 16-lane read or one 16-lane write.

A quarter reads its three sources on three consecutive cycles. It multiplies and adds on the fourth cycle and writes its bank in that same cycle. Quarter k starts one cycle after quarter k-1. In steady state the three reads and the one write of any cycle therefore fall on four different banks. A new instruction is accepted every four cycles, and an instruction may consume the result of the one just before it with no stall.

A host port preloads and reads back whole 16-lane bank rows, but only while the pipeline is idle. `busy` tells the host when that is allowed.

Top module: `lane_banked_simd`

## Requirements
- R1: After reset, issue_ready is 1, busy is 0 and host_rvalid is 0.
- R2: For every lane j of 0..63, the instruction writes (src0 * src1 + src2) mod 2^32 into register dst. Lanes 16k..16k+15 live in bank k, and lane j of a bank row sits at bits [32*(j mod 16)+31 : 32*(j mod 16)].
- R3: An instruction is accepted in a cycle where issue_valid and issue_ready are both 1. issue_ready is then 0 for the next three cycles and 1 again on the fourth, so back-to-back instructions are accepted exactly 4 cycles apart.
- R4: Quarter k begins fetching one cycle after quarter k-1. busy goes high the cycle after acceptance and stays high for 7 cycles for a lone instruction, or 4N+3 cycles for N back-to-back instructions.
- R5: An instruction that reads the destination of the immediately preceding instruction gets that instruction's result, and is still accepted 4 cycles after it.
- R6: An instruction whose destination is also one or more of its sources uses the register's old value for every source.
- R7: With busy low, a host_req with host_we=1 writes host_wdata into row host_addr of bank host_bank (0..3). A host_req with host_we=0 returns that row on host_rdata in the next cycle, with host_rvalid high for that one cycle.
- R8: A host_req made while busy is 1 is ignored: no register changes, and host_rvalid stays 0.
- R9: issue_valid in a cycle where issue_ready is 0 is ignored. No instruction is started, and busy is not extended.
- R10: No bank ever sees more than one access in a cycle. A pipeline access always takes precedence over the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction can be taken this cycle |
| issue_dst | input | log2(NREG) | Destination register index |
| issue_src0 | input | log2(NREG) | Multiplicand register index |
| issue_src1 | input | log2(NREG) | Multiplier register index |
| issue_src2 | input | log2(NREG) | Addend register index |
| busy | output | 1 | Any quarter pass in flight |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_bank | input | log2(QUARTERS) | Bank (lane quarter) selected |
| host_addr | input | log2(NREG) | Register row selected |
| host_wdata | input | LANES*DW | Row written by the host |
| host_rvalid | output | 1 | host_rdata holds a read result |
| host_rdata | output | LANES*DW | Row read by the host |

## Verification
The multiply-add is tried with mixed hashed operands whose products overflow 32 bits, with an all-ones multiplicand combined with a zero addend, with a chain of three dependent instructions issued back to back, and with an instruction that writes one of its own sources. The hashed values differ lane by lane and bank by bank, so a wrong lane slice or a wrong bank row shows up. The dependent chain tells a correct same-bank write-then-read apart from a stale read or a stall, which would move the accept spacing and the busy length. The self-referencing case separates reading before the quarter's write from reading after it. Host requests and issue offers made while the pipeline cannot take them confirm that neither changes any register or the timing.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_F0   = 3'd1,
    PH_F1   = 3'd2,
    PH_F2   = 3'd3,
    PH_EX   = 3'd4
  } phase_e;
endpackage

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int LANES = 16,
  parameter int DW    = 32,
  parameter int NREG  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] addr,
  input  logic [LANES*DW-1:0]     wdata,
  output logic [LANES*DW-1:0]     rdata
);
  localparam int RW = LANES * DW;

  logic [RW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // A row written in one cycle is returned by a read of it in the next
  assert_write_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we && $past(en && we) && (addr == $past(addr))) |-> (rdata == $past(wdata)));
endmodule

// File: rtl/lane_madd.sv
module lane_madd #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic [LANES*DW-1:0] mul_a,
  input  logic [LANES*DW-1:0] mul_b,
  input  logic [LANES*DW-1:0] add_c,
  output logic [LANES*DW-1:0] res
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign res[l*DW +: DW] = mul_a[l*DW +: DW] * mul_b[l*DW +: DW] + add_c[l*DW +: DW];
  end
endmodule

// File: rtl/quarter_slice.sv
module quarter_slice #(
  parameter int LANES = 16,
  parameter int DW    = 32,
  parameter int NREG  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_s0,
  input  logic [$clog2(NREG)-1:0] in_s1,
  input  logic [$clog2(NREG)-1:0] in_s2,
  output logic                    fwd_start,
  output logic [$clog2(NREG)-1:0] fwd_dst,
  output logic [$clog2(NREG)-1:0] fwd_s0,
  output logic [$clog2(NREG)-1:0] fwd_s1,
  output logic [$clog2(NREG)-1:0] fwd_s2,
  output logic                    slot_free,
  output logic                    active,
  input  logic                    host_en,
  input  logic                    host_we,
  input  logic [$clog2(NREG)-1:0] host_addr,
  input  logic [LANES*DW-1:0]     host_wdata,
  output logic [LANES*DW-1:0]     bank_rdata
);
  localparam int AW = $clog2(NREG);
  localparam int RW = LANES * DW;

  lbs_pkg::phase_e phase_q, phase_d;
  logic [AW-1:0]   dst_q, s0_q, s1_q, s2_q;
  logic [RW-1:0]   opa_q, opb_q, opc_q;
  logic [RW-1:0]   madd_y;
  logic            pipe_on;
  logic            b_en, b_we;
  logic [AW-1:0]   b_addr;
  logic [RW-1:0]   b_wdata;

  // next phase
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      lbs_pkg::PH_IDLE: if (start) phase_d = lbs_pkg::PH_F0;
      lbs_pkg::PH_F0:   phase_d = lbs_pkg::PH_F1;
      lbs_pkg::PH_F1:   phase_d = lbs_pkg::PH_F2;
      lbs_pkg::PH_F2:   phase_d = lbs_pkg::PH_EX;
      lbs_pkg::PH_EX:   phase_d = start ? lbs_pkg::PH_F0 : lbs_pkg::PH_IDLE;
      default:          phase_d = lbs_pkg::PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= lbs_pkg::PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  // instruction fields, loaded when this quarter starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      s0_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else if (start) begin
      dst_q <= in_dst;
      s0_q  <= in_s0;
      s1_q  <= in_s1;
      s2_q  <= in_s2;
    end
  end

  // operand capture, one source per fetch cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
      opc_q <= '0;
    end else begin
      if (phase_q == lbs_pkg::PH_F0) opa_q <= bank_rdata;
      if (phase_q == lbs_pkg::PH_F1) opb_q <= bank_rdata;
      if (phase_q == lbs_pkg::PH_F2) opc_q <= bank_rdata;
    end
  end

  lane_madd #(.LANES(LANES), .DW(DW)) u_madd (
    .mul_a (opa_q),
    .mul_b (opb_q),
    .add_c (opc_q),
    .res   (madd_y)
  );

  // single bank port: pipeline first, host otherwise
  always_comb begin
    pipe_on = (phase_q != lbs_pkg::PH_IDLE);
    b_en    = pipe_on | host_en;
    b_we    = 1'b0;
    b_addr  = host_addr;
    b_wdata = host_wdata;
    if (pipe_on) begin
      b_wdata = madd_y;
      unique case (phase_q)
        lbs_pkg::PH_F0: b_addr = s0_q;
        lbs_pkg::PH_F1: b_addr = s1_q;
        lbs_pkg::PH_F2: b_addr = s2_q;
        default: begin
          b_addr = dst_q;
          b_we   = 1'b1;
        end
      endcase
    end else begin
      b_we = host_we;
    end
  end

  lane_bank #(.LANES(LANES), .DW(DW), .NREG(NREG)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (b_en),
    .we    (b_we),
    .addr  (b_addr),
    .wdata (b_wdata),
    .rdata (bank_rdata)
  );

  assign fwd_start = (phase_q == lbs_pkg::PH_F0);
  assign fwd_dst   = dst_q;
  assign fwd_s0    = s0_q;
  assign fwd_s1    = s1_q;
  assign fwd_s2    = s2_q;
  assign slot_free = (phase_q == lbs_pkg::PH_IDLE) || (phase_q == lbs_pkg::PH_EX);
  assign active    = pipe_on;

  // host and pipeline never meet on this bank
  assert_single_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && (phase_q != lbs_pkg::PH_IDLE)));

  // a new pass only starts when the previous one is writing or gone
  assert_start_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ((phase_q == lbs_pkg::PH_IDLE) || (phase_q == lbs_pkg::PH_EX)));
endmodule

// File: rtl/lane_banked_simd.sv
module lane_banked_simd #(
  parameter int LANES    = 16,
  parameter int QUARTERS = 4,
  parameter int DW       = 32,
  parameter int NREG     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issue_valid,
  output logic                        issue_ready,
  input  logic [$clog2(NREG)-1:0]     issue_dst,
  input  logic [$clog2(NREG)-1:0]     issue_src0,
  input  logic [$clog2(NREG)-1:0]     issue_src1,
  input  logic [$clog2(NREG)-1:0]     issue_src2,
  output logic                        busy,
  input  logic                        host_req,
  input  logic                        host_we,
  input  logic [$clog2(QUARTERS)-1:0] host_bank,
  input  logic [$clog2(NREG)-1:0]     host_addr,
  input  logic [LANES*DW-1:0]         host_wdata,
  output logic                        host_rvalid,
  output logic [LANES*DW-1:0]         host_rdata
);
  localparam int AW = $clog2(NREG);
  localparam int RW = LANES * DW;

  logic                accept;
  logic                host_ok;
  logic [QUARTERS-1:0] q_start, q_fwd, q_free, q_active, q_hen;
  logic [AW-1:0]       in_dst [QUARTERS];
  logic [AW-1:0]       in_s0  [QUARTERS];
  logic [AW-1:0]       in_s1  [QUARTERS];
  logic [AW-1:0]       in_s2  [QUARTERS];
  logic [AW-1:0]       fw_dst [QUARTERS];
  logic [AW-1:0]       fw_s0  [QUARTERS];
  logic [AW-1:0]       fw_s1  [QUARTERS];
  logic [AW-1:0]       fw_s2  [QUARTERS];
  logic [RW-1:0]       bank_rd [QUARTERS];
  logic                rvalid_d;
  logic [RW-1:0]       rdata_d;

  assign issue_ready = q_free[0];
  assign accept      = issue_valid & issue_ready;
  assign busy        = |q_active;
  assign host_ok     = host_req & ~busy;

  for (genvar k = 0; k < QUARTERS; k++) begin : g_quarter
    if (k == 0) begin : g_head
      assign q_start[k] = accept;
      assign in_dst[k]  = issue_dst;
      assign in_s0[k]   = issue_src0;
      assign in_s1[k]   = issue_src1;
      assign in_s2[k]   = issue_src2;
    end else begin : g_chain
      assign q_start[k] = q_fwd[k-1];
      assign in_dst[k]  = fw_dst[k-1];
      assign in_s0[k]   = fw_s0[k-1];
      assign in_s1[k]   = fw_s1[k-1];
      assign in_s2[k]   = fw_s2[k-1];

      // quarter k fetches its first source one cycle after quarter k-1
      assert_quarter_stagger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q_fwd[k-1] |=> q_fwd[k]);
    end

    assign q_hen[k] = host_ok & (host_bank == k);

    quarter_slice #(.LANES(LANES), .DW(DW), .NREG(NREG)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (q_start[k]),
      .in_dst     (in_dst[k]),
      .in_s0      (in_s0[k]),
      .in_s1      (in_s1[k]),
      .in_s2      (in_s2[k]),
      .fwd_start  (q_fwd[k]),
      .fwd_dst    (fw_dst[k]),
      .fwd_s0     (fw_s0[k]),
      .fwd_s1     (fw_s1[k]),
      .fwd_s2     (fw_s2[k]),
      .slot_free  (q_free[k]),
      .active     (q_active[k]),
      .host_en    (q_hen[k]),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .bank_rdata (bank_rd[k])
    );
  end

  // host readback register
  always_comb begin
    rvalid_d = host_ok & ~host_we;
    rdata_d  = rvalid_d ? bank_rd[host_bank] : host_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rvalid_d;
      host_rdata  <= rdata_d;
    end
  end

  // three cycles of not-ready follow each acceptance
  assert_ready_cadence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ready |-> !($past(accept, 1) || $past(accept, 2) || $past(accept, 3)));

  // the pipeline is busy the cycle after an acceptance
  assert_busy_after_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // host requests made while busy produce no read data
  assert_host_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && busy) |=> !host_rvalid);
endmodule

// File: tb/lane_banked_simd_bench.sv
module lane_banked_simd_bench;
  localparam int LANES = 16;
  localparam int QUARTERS = 4;
  localparam int DW = 32;
  localparam int NREG = 16;
  localparam int RW = LANES * DW;

  logic          clk;
  logic          rst_n;
  logic          issue_valid, issue_ready;
  logic [3:0]    issue_dst, issue_src0, issue_src1, issue_src2;
  logic          busy;
  logic          host_req, host_we;
  logic [1:0]    host_bank;
  logic [3:0]    host_addr;
  logic [RW-1:0] host_wdata;
  logic          host_rvalid;
  logic [RW-1:0] host_rdata;

  lane_banked_simd #(.LANES(LANES), .QUARTERS(QUARTERS), .DW(DW), .NREG(NREG)) u_lane_banked_simd (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_dst(issue_dst), .issue_src0(issue_src0), .issue_src1(issue_src1), .issue_src2(issue_src2),
    .busy(busy),
    .host_req(host_req), .host_we(host_we), .host_bank(host_bank), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int stamp = 0;
  bit done = 0;
  logic [31:0] mdl [QUARTERS][NREG][LANES];

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int q, input int r, input int l, input int seed);
    logic [31:0] x;
    x = 32'(q * 1000 + r * 37 + l * 5 + seed + 1);
    return x * 32'h9E3779B1;
  endfunction

  function automatic logic [RW-1:0] row_of(input int q, input int r);
    logic [RW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*DW +: DW] = mdl[q][r][l];
    return v;
  endfunction

  task automatic host_wr(input int q, input int r);
    @(negedge clk);
    host_req = 1; host_we = 1; host_bank = 2'(q); host_addr = 4'(r);
    host_wdata = row_of(q, r);
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic host_rd(input int q, input int r, output logic [RW-1:0] got, output logic rv);
    @(negedge clk);
    host_req = 1; host_we = 0; host_bank = 2'(q); host_addr = 4'(r);
    @(negedge clk);
    host_req = 0;
    got = host_rdata;
    rv = host_rvalid;
  endtask

  task automatic check_reg(input int r, input string req);
    logic [RW-1:0] got;
    logic rv;
    for (int q = 0; q < QUARTERS; q++) begin
      host_rd(q, r, got, rv);
      chk(rv && (got == row_of(q, r)), req, got, row_of(q, r));
    end
  endtask

  // lane-wise reference: all reads happen before the write
  task automatic model_op(input int d, input int a, input int b, input int c);
    logic [31:0] t;
    for (int q = 0; q < QUARTERS; q++)
      for (int l = 0; l < LANES; l++) begin
        t = mdl[q][a][l] * mdl[q][b][l] + mdl[q][c][l];
        mdl[q][d][l] = t;
      end
  endtask

  // offers an instruction, returns at the negedge after the accepting edge
  task automatic issue_one(input int d, input int a, input int b, input int c);
    issue_valid = 1; issue_dst = 4'(d); issue_src0 = 4'(a); issue_src1 = 4'(b); issue_src2 = 4'(c);
    while (!issue_ready) @(negedge clk);
    stamp = cyc;
    @(negedge clk);
    issue_valid = 0;
    model_op(d, a, b, c);
  endtask

  task automatic wait_idle(output int at);
    while (busy) @(negedge clk);
    at = cyc;
  endtask

  task automatic t_reset;
    chk(issue_ready == 1, "R1 ready", RW'(issue_ready), RW'(1));
    chk(busy == 0, "R1 busy", RW'(busy), RW'(0));
    chk(host_rvalid == 0, "R1 rvalid", RW'(host_rvalid), RW'(0));
  endtask

  task automatic t_host_preload;
    for (int r = 0; r < 8; r++)
      for (int q = 0; q < QUARTERS; q++) begin
        for (int l = 0; l < LANES; l++)
          mdl[q][r][l] = (r == 6) ? 32'hFFFF_FFFF : (r == 7) ? 32'h0 : pat(q, r, l, 0);
        host_wr(q, r);
      end
    check_reg(1, "R7 readback r1");
    check_reg(6, "R7 readback r6");
  endtask

  task automatic t_single;
    int t0, t1;
    issue_one(8, 1, 2, 3);
    t0 = stamp;
    chk(issue_ready == 0, "R3 ready low after accept", RW'(issue_ready), RW'(0));
    chk(busy == 1, "R4 busy after accept", RW'(busy), RW'(1));
    wait_idle(t1);
    chk((t1 - t0) == 8, "R4 lone busy length", RW'(t1 - t0), RW'(8));
    check_reg(8, "R2 mixed operands");
    issue_one(9, 6, 4, 7);
    wait_idle(t1);
    check_reg(9, "R2 all-ones times value plus zero");
  endtask

  task automatic t_back_to_back;
    int a0, a1, a2, t1;
    issue_one(10, 1, 2, 3);
    a0 = stamp;
    issue_one(11, 10, 4, 10);
    a1 = stamp;
    issue_one(12, 11, 11, 5);
    a2 = stamp;
    chk((a1 - a0) == 4, "R3 accept spacing 1", RW'(a1 - a0), RW'(4));
    chk((a2 - a1) == 4, "R5 dependent accept spacing", RW'(a2 - a1), RW'(4));
    wait_idle(t1);
    chk((t1 - a0) == 16, "R4 busy length for three", RW'(t1 - a0), RW'(16));
    check_reg(10, "R5 chain head");
    check_reg(11, "R5 dependent on previous");
    check_reg(12, "R5 dependent twice");
  endtask

  task automatic t_self;
    int t1;
    issue_one(2, 2, 2, 2);
    wait_idle(t1);
    check_reg(2, "R6 self reference uses old value");
  endtask

  task automatic t_host_busy;
    logic [RW-1:0] got;
    logic rv;
    int t1;
    issue_one(13, 3, 4, 5);
    @(negedge clk);
    host_req = 1; host_we = 1; host_bank = 0; host_addr = 1; host_wdata = '1;
    @(negedge clk);
    host_req = 0;
    host_rd(1, 4, got, rv);
    chk(rv == 0, "R8 read while busy gives no data", RW'(rv), RW'(0));
    wait_idle(t1);
    check_reg(1, "R8 write while busy ignored");
    check_reg(13, "R10 result intact next to host attempt");
  endtask

  task automatic t_ignore_offer;
    int t0, t1;
    issue_one(14, 1, 3, 5);
    t0 = stamp;
    issue_valid = 1; issue_dst = 4'd15; issue_src0 = 4'd1; issue_src1 = 4'd1; issue_src2 = 4'd1;
    chk(issue_ready == 0, "R9 offer while not ready", RW'(issue_ready), RW'(0));
    @(negedge clk);
    issue_valid = 0;
    for (int q = 0; q < QUARTERS; q++)
      for (int l = 0; l < LANES; l++) mdl[q][15][l] = 32'h5A5A_0000 + 32'(q * 16 + l);
    wait_idle(t1);
    chk((t1 - t0) == 8, "R9 busy not extended", RW'(t1 - t0), RW'(8));
    check_reg(14, "R9 accepted instruction result");
    for (int q = 0; q < QUARTERS; q++) host_wr(q, 15);
    check_reg(15, "R9 ignored offer wrote nothing later");
  endtask

  initial begin
    rst_n = 0; issue_valid = 0; issue_dst = 0; issue_src0 = 0; issue_src1 = 0; issue_src2 = 0;
    host_req = 0; host_we = 0; host_bank = 0; host_addr = 0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_host_preload;
    t_single;
    t_back_to_back;
    t_self;
    t_host_busy;
    t_ignore_offer;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule